// File: doc/BRIEF.md
# Page-Wrapping Memory Address Counter

This block keeps the internal byte pointer of a small serial EEPROM. A bus controller loads it with the word-address byte from a write header. On the larger array sizes the one or two page-select bits from the device address word sit above that byte. The controller then pulses an advance strobe once for each data byte it moves. The pointer keeps its value between transactions, so a later read with no address phase continues from where the last access stopped.

The advance rule depends on the direction of transfer. A write advance wraps inside the current page: only the low page-offset bits count, and the row bits do not change. A read advance counts through the whole array and wraps from the last byte back to address zero. A size selector picks one of three geometries at run time:

| Size | Array | Write page |
|---|---|---|
| Small | 256 bytes | 8 bytes |
| Medium | 512 bytes | 16 bytes |
| Large | 1024 bytes | 16 bytes |

Top module: `eeprom_addr_ptr`

## Requirements
- R1: A clock edge with `rst_n` low sets `addr_o` to 0.
- R2: With `size_sel_i` = 0 (256 bytes), a load sets `addr_o` to `{2'b00, word_addr_i}` and `page_bits_i` has no effect.
- R3: With `size_sel_i` = 1 (512 bytes), a load sets `addr_o[7:0]` = `word_addr_i`, `addr_o[8]` = `page_bits_i[0]` and `addr_o[9]` = 0.
- R4: With `size_sel_i` = 2 or 3 (1024 bytes), a load sets `addr_o` to `{page_bits_i, word_addr_i}`.
- R5: An advance with `is_read_i` = 0 increments only the low 3 bits (size 0) or the low 4 bits (sizes 1 to 3). Higher bits are held, so the pointer steps from the last byte of a page to the first byte of the same page.
- R6: An advance with `is_read_i` = 1 adds one modulo the array size (256, 512 or 1024). It crosses page boundaries and goes from the last byte of the array to 0.
- R7: In a cycle with neither strobe, `addr_o` keeps its value whatever the other inputs do.
- R8: When `load_i` and `adv_i` are both high, the load takes effect and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load the pointer from the address inputs |
| word_addr_i | input | 8 | Word-address byte |
| page_bits_i | input | 2 | Page-select bits from the device address word |
| adv_i | input | 1 | Advance after one data byte |
| is_read_i | input | 1 | 1: read advance rule, 0: write advance rule |
| size_sel_i | input | 2 | 0: 256 B, 1: 512 B, 2 or 3: 1024 B |
| addr_o | output | 10 | Current pointer |

## Verification
The bench aims at the wrap points.

| Scenario | Faulty behaviour it would catch |
|---|---|
| Write advance past the last byte of an 8-byte page and of a 16-byte page | A counter with the wrong page width leaves the page. A counter using the read rule carries into the row bits. |
| Read advance from 0x0FF at the medium size | A pointer that uses the write rule for reads stays inside the page instead of reaching 0x100. |
| Read advance from the last byte of each array size | A pointer that ignores the size setting does not return to 0. |
| Loads with page bits set on the small and medium sizes | A pointer that does not mask the page bits shows them in the output. |
| Both strobes high in the same cycle | A pointer with the wrong priority ends one byte past the loaded value. |

// File: rtl/addr_ptr_pkg.sv
// Package: shared widths and the size-select encoding for the pointer.
package addr_ptr_pkg;
    localparam int WORD_AW       = 8;   // width of the word-address byte
    localparam int MAX_AW        = 10;  // pointer width for the largest array
    localparam int BANK_W        = MAX_AW - WORD_AW;
    localparam int PAGE_AW_SMALL = 3;   // 8-byte write page
    localparam int PAGE_AW_LARGE = 4;   // 16-byte write page

    typedef enum logic [1:0] {
        SZ_256  = 2'd0,
        SZ_512  = 2'd1,
        SZ_1K   = 2'd2,
        SZ_1K_B = 2'd3
    } size_sel_e;
endpackage

// File: rtl/ptr_geometry.sv
// Module: ptr_geometry
// Turns the size selector into two bit masks.
//   page_mask_o:  the bits that count on a write advance.
//   array_mask_o: the bits that exist in the selected array.
// Assumes: the codes for size 2 and size 3 mean the same array.
module ptr_geometry
    import addr_ptr_pkg::*;
#(
    parameter int AW       = MAX_AW,
    parameter int W_AW     = WORD_AW,
    parameter int PG_SMALL = PAGE_AW_SMALL,
    parameter int PG_LARGE = PAGE_AW_LARGE
) (
    input  logic [1:0]    size_sel_i,
    output logic [AW-1:0] page_mask_o,
    output logic [AW-1:0] array_mask_o
);
    int unsigned page_w;
    int unsigned array_w;

    // Pick the page width and array width for the selected size.
    always_comb begin
        case (size_sel_e'(size_sel_i))
            SZ_256: begin
                page_w  = PG_SMALL;
                array_w = W_AW;
            end
            SZ_512: begin
                page_w  = PG_LARGE;
                array_w = W_AW + 1;
            end
            default: begin
                page_w  = PG_LARGE;
                array_w = AW;
            end
        endcase
    end

    // Build each mask bit from the bit position and the selected widths.
    for (genvar i = 0; i < AW; i++) begin : g_mask
        assign page_mask_o[i]  = (i < page_w);
        assign array_mask_o[i] = (i < array_w);
    end
endmodule

// File: rtl/ptr_load_fmt.sv
// Module: ptr_load_fmt
// Builds the load value. The word byte is placed in the low bits.
// The page bits are placed above it, and only those the array has are kept.
// Assumes: array_mask_i always covers the full word byte.
module ptr_load_fmt
    import addr_ptr_pkg::*;
#(
    parameter int AW   = MAX_AW,
    parameter int W_AW = WORD_AW,
    localparam int BW  = AW - W_AW
) (
    input  logic [W_AW-1:0] word_addr_i,
    input  logic [BW-1:0]   page_bits_i,
    input  logic [AW-1:0]   array_mask_i,
    output logic [AW-1:0]   load_val_o
);
    // Join the page bits and the word byte, then clear the bits above the array.
    always_comb begin
        load_val_o            = {page_bits_i, word_addr_i};
        load_val_o[AW-1:W_AW] = page_bits_i & array_mask_i[AW-1:W_AW];
    end
endmodule

// File: rtl/ptr_step.sv
// Module: ptr_step
// Works out the pointer value that follows one data byte.
//   Write rule: only the page-offset bits count; higher bits are held.
//   Read rule: the whole array counts, modulo its size.
// Assumes: the masks come from ptr_geometry.
module ptr_step
    import addr_ptr_pkg::*;
#(
    parameter int AW = MAX_AW
) (
    input  logic [AW-1:0] cur_i,
    input  logic          is_read_i,
    input  logic [AW-1:0] page_mask_i,
    input  logic [AW-1:0] array_mask_i,
    output logic [AW-1:0] next_o
);
    logic [AW-1:0] plus_one;

    // Add one to the current pointer; the carry out of the top bit is dropped.
    assign plus_one = cur_i + {{(AW-1){1'b0}}, 1'b1};

    // Apply the read or write rule to the incremented value.
    always_comb begin
        if (is_read_i) begin
            next_o = plus_one & array_mask_i;
        end else begin
            next_o = (cur_i & ~page_mask_i) | (plus_one & page_mask_i);
        end
    end
endmodule

// File: rtl/eeprom_addr_ptr.sv
// Module: eeprom_addr_ptr (top)
// Holds the EEPROM data-word pointer across transactions.
// A load takes priority over an advance in the same cycle.
// The pointer is held in any cycle with no strobe.
// Assumes: synchronous active-low reset; one advance pulse per data byte.
module eeprom_addr_ptr
    import addr_ptr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [WORD_AW-1:0]  word_addr_i,
    input  logic [BANK_W-1:0]   page_bits_i,
    input  logic                adv_i,
    input  logic                is_read_i,
    input  logic [1:0]          size_sel_i,
    output logic [MAX_AW-1:0]   addr_o
);
    logic [MAX_AW-1:0] page_mask;
    logic [MAX_AW-1:0] array_mask;
    logic [MAX_AW-1:0] load_val;
    logic [MAX_AW-1:0] step_val;
    logic [MAX_AW-1:0] addr_q;

    ptr_geometry #(
        .AW       (MAX_AW),
        .W_AW     (WORD_AW),
        .PG_SMALL (PAGE_AW_SMALL),
        .PG_LARGE (PAGE_AW_LARGE)
    ) geom_i (
        .size_sel_i   (size_sel_i),
        .page_mask_o  (page_mask),
        .array_mask_o (array_mask)
    );

    ptr_load_fmt #(
        .AW   (MAX_AW),
        .W_AW (WORD_AW)
    ) fmt_i (
        .word_addr_i  (word_addr_i),
        .page_bits_i  (page_bits_i),
        .array_mask_i (array_mask),
        .load_val_o   (load_val)
    );

    ptr_step #(
        .AW (MAX_AW)
    ) step_i (
        .cur_i        (addr_q),
        .is_read_i    (is_read_i),
        .page_mask_i  (page_mask),
        .array_mask_i (array_mask),
        .next_o       (step_val)
    );

    // Pointer register: reset, then load, then advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= load_val;
        end else if (adv_i) begin
            addr_q <= step_val;
        end
    end

    assign addr_o = addr_q;

    // R4 and R8: at the 1024-byte size a load copies the page bits and word byte unchanged.
    a_r4_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && size_sel_i[1]) |=> (addr_o == {$past(page_bits_i), $past(word_addr_i)}));

    // R2: at the 256-byte size a load leaves the bits above the word byte at zero.
    a_r2_load_small: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && size_sel_i == 2'd0) |=> (addr_o[MAX_AW-1:WORD_AW] == '0));

    // R5: a write advance never changes the bits above the largest page offset.
    a_r5_write_row_held: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && !is_read_i)
        |=> (addr_o[MAX_AW-1:PAGE_AW_LARGE] == $past(addr_o[MAX_AW-1:PAGE_AW_LARGE])));

    // R6: at the 1024-byte size a read advance is a plain increment with natural wrap.
    a_r6_read_full_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && is_read_i && size_sel_i[1])
        |=> (addr_o == $past(addr_o) + 10'd1));

    // R7: with no strobe the pointer holds its value.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(addr_o));
endmodule

// File: tb/eeprom_addr_ptr_tb_top.sv
`timescale 1ns/1ps
// Directed bench for eeprom_addr_ptr. There is one task per scenario, and each task checks its own results.
module eeprom_addr_ptr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] word_addr_i = 8'h00;
    logic [1:0] page_bits_i = 2'b00;
    logic       adv_i = 1'b0;
    logic       is_read_i = 1'b0;
    logic [1:0] size_sel_i = 2'd0;
    logic [9:0] addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    eeprom_addr_ptr dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .word_addr_i (word_addr_i),
        .page_bits_i (page_bits_i),
        .adv_i       (adv_i),
        .is_read_i   (is_read_i),
        .size_sel_i  (size_sel_i),
        .addr_o      (addr_o)
    );

    // Compare addr_o with the expected value and count the result.
    task automatic check(input string req, input logic [9:0] exp);
        checks++;
        if (addr_o !== exp) begin
            errors++;
            $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, then sample at the next falling edge.
    task automatic cyc(input logic ld, input logic [7:0] wa, input logic [1:0] pb,
                       input logic adv, input logic rd, input logic [1:0] sz);
        load_i = ld; word_addr_i = wa; page_bits_i = pb;
        adv_i = adv; is_read_i = rd; size_sel_i = sz;
        @(negedge clk);
        load_i = 1'b0; adv_i = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset", 10'h000);
    endtask

    task automatic t_loads();
        cyc(1, 8'hA5, 2'b11, 0, 0, 2'd0); check("R2 load small", 10'h0A5);
        cyc(1, 8'h12, 2'b11, 0, 0, 2'd1); check("R3 load medium", 10'h112);
        cyc(1, 8'h34, 2'b10, 0, 0, 2'd2); check("R4 load large", 10'h234);
        cyc(1, 8'hFF, 2'b01, 0, 0, 2'd3); check("R4 load code 3", 10'h1FF);
    endtask

    task automatic t_write_wrap();
        cyc(1, 8'h3E, 2'b11, 0, 0, 2'd0);
        cyc(0, 8'h00, 2'b00, 1, 0, 2'd0); check("R5 small step", 10'h03F);
        cyc(0, 8'h00, 2'b00, 1, 0, 2'd0); check("R5 small page wrap", 10'h038);
        cyc(1, 8'hFE, 2'b11, 0, 0, 2'd2);
        cyc(0, 8'h00, 2'b00, 1, 0, 2'd2); check("R5 large step", 10'h3FF);
        cyc(0, 8'h00, 2'b00, 1, 0, 2'd2); check("R5 large page wrap", 10'h3F0);
        for (int i = 0; i < 16; i++) cyc(0, 8'h00, 2'b00, 1, 0, 2'd2);
        check("R5 sixteen steps return", 10'h3F0);
    endtask

    task automatic t_read_wrap();
        cyc(1, 8'hFF, 2'b00, 0, 1, 2'd0);
        cyc(0, 8'h00, 2'b00, 1, 1, 2'd0); check("R6 small array wrap", 10'h000);
        cyc(1, 8'hFF, 2'b00, 0, 1, 2'd1);
        cyc(0, 8'h00, 2'b00, 1, 1, 2'd1); check("R6 medium page cross", 10'h100);
        cyc(1, 8'hFF, 2'b01, 0, 1, 2'd1);
        cyc(0, 8'h00, 2'b00, 1, 1, 2'd1); check("R6 medium array wrap", 10'h000);
        cyc(1, 8'hFF, 2'b11, 0, 1, 2'd2);
        cyc(0, 8'h00, 2'b00, 1, 1, 2'd2); check("R6 large array wrap", 10'h000);
    endtask

    task automatic t_hold();
        cyc(1, 8'h5A, 2'b01, 0, 0, 2'd2);
        cyc(0, 8'hC3, 2'b10, 0, 1, 2'd0);
        cyc(0, 8'h11, 2'b11, 0, 0, 2'd1);
        check("R7 hold without strobe", 10'h15A);
    endtask

    task automatic t_priority();
        cyc(1, 8'h77, 2'b10, 1, 1, 2'd2); check("R8 load beats advance", 10'h277);
    endtask

    // Watchdog: an expired run counts as a failed check and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: addr_o=%h expected=finish", addr_o);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_loads();
        t_write_wrap();
        t_read_wrap();
        t_hold();
        t_priority();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule